// File: doc/BRIEF.md
# DRAM Read-Disturbance Stress Sequencer

This block produces DRAM command streams that deliberately disturb neighbouring rows, for use on a memory test platform. A single start pulse loads a job: the target bank, a table of aggressor row addresses, how many of them to use, a 32-bit iteration count, and three timing values. These are the minimum activate-to-precharge gap, the recovery gap after a precharge, and an extended open time. The block then drives one command per clock slot onto a small command port. Each slot carries an opcode for idle, activate or precharge, together with a bank field and a row field.

The block has two modes. In hammer mode each iteration opens one aggressor row and closes it again. Successive iterations step through the aggressor table in order and wrap back to the first entry. With two entries this is a ping-pong pattern. With four, seven or nine entries it is a many-sided pattern. In press mode every iteration opens the first table entry and holds it open for the longer of the open time and the minimum gap, then closes it. A one-cycle done pulse marks the normal end of a job. A synchronous abort ends a job early and closes any row left open.

Top module: `dram_disturb_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, the command is idle (code 0), busy is low and done is low.
- R2: In hammer mode iteration k activates table entry k mod N, where N is the aggressor count. A count of 0 acts as 1 and a count above the table depth acts as the depth. The table is flat, and entry i sits at bits i*ROW_W upward. The first activate appears in the cycle after the start pulse is sampled.
- R3: Command codes are 1 for activate and 2 for precharge. A precharge follows its activate by max(tras,1) cycles in hammer mode. The next activate follows a precharge by max(trp,1) cycles. Idle slots carry code 0.
- R4: In press mode every activate targets table entry 0. Its precharge follows after max(tras,open_time,1) cycles.
- R5: A job with iteration count N (32 bits) issues exactly N activates and N precharges. A count of 0 issues no command and pulses done in the cycle after start.
- R6: Done is high for exactly one cycle, max(trp,1) cycles after the final precharge. Busy is low in that cycle, and no row is open.
- R7: A start pulse while busy is ignored. Changes to any job input while busy do not alter the running sequence.
- R8: Abort while busy returns the block to idle in the next cycle without a done pulse. If a row is open, that cycle carries one precharge to that row and bank. Abort has priority over a start pulse that arrives in the same cycle while idle.
- R9: Every command carries the bank latched at start. A precharge only closes the row opened by the preceding activate, and no activate is issued while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Job start pulse, accepted only when idle |
| abort_i | input | 1 | Synchronous abort |
| press_mode_i | input | 1 | 1 selects press mode, 0 selects hammer mode |
| agg_count_i | input | AGG_CNT_W | Number of aggressor table entries in use |
| agg_rows_i | input | MAX_AGG*ROW_W | Flat aggressor row table |
| bank_i | input | BANK_W | Target bank |
| iter_i | input | ITER_W | Iteration count |
| t_ras_i | input | TRAS_W | Minimum activate-to-precharge gap |
| t_rp_i | input | TRP_W | Gap after precharge |
| open_time_i | input | OPEN_W | Press-mode open time |
| cmd_o | output | 2 | Command: 0 idle, 1 activate, 2 precharge |
| cmd_bank_o | output | BANK_W | Bank field of the command |
| cmd_row_o | output | ROW_W | Row field of the command |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The critical collision is an abort in the same cycle that the sequencer's own counter schedules a precharge. Both events want to close the row, and the block must emit exactly one precharge and then fall idle with no done. The bench provokes this by raising abort on the last open-gap cycle. It also raises abort with a row open earlier in the gap, during the recovery gap, and together with a start pulse while idle. In each case it compares every following slot against a model trace built from the requirements, and it sweeps random jobs to cover the normal case.

// File: rtl/disturb_pkg.sv
package disturb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_PRE = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_RECOV = 2'd2
    } state_e;

endpackage

// File: rtl/disturb_row_pick.sv
module disturb_row_pick #(
    parameter int ROW_W   = 16,
    parameter int MAX_AGG = 16,
    parameter int IDX_W   = 4
) (
    input  logic [MAX_AGG*ROW_W-1:0] rows_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [ROW_W-1:0]         row_o
);

    logic [ROW_W-1:0] tbl [MAX_AGG];

    for (genvar g = 0; g < MAX_AGG; g++) begin : g_slice
        assign tbl[g] = rows_i[g*ROW_W +: ROW_W];
    end

    always_comb begin
        row_o = tbl[0];
        for (int i = 0; i < MAX_AGG; i++) begin
            if (int'(idx_i) == i) begin
                row_o = tbl[i];
            end
        end
    end

endmodule

// File: rtl/disturb_gap_len.sv
module disturb_gap_len #(
    parameter int TRAS_W = 8,
    parameter int TRP_W  = 8,
    parameter int OPEN_W = 24
) (
    input  logic              press_i,
    input  logic [TRAS_W-1:0] t_ras_i,
    input  logic [TRP_W-1:0]  t_rp_i,
    input  logic [OPEN_W-1:0] open_i,
    output logic [OPEN_W-1:0] open_len_o,
    output logic [TRP_W-1:0]  rp_len_o
);

    logic [OPEN_W-1:0] ras_ext;
    logic [OPEN_W-1:0] hold;

    always_comb begin
        ras_ext = OPEN_W'(t_ras_i);
        hold    = ras_ext;
        if (press_i && (open_i > ras_ext)) begin
            hold = open_i;
        end
        open_len_o = (hold == '0) ? OPEN_W'(1) : hold;
        rp_len_o   = (t_rp_i == '0) ? TRP_W'(1) : t_rp_i;
    end

endmodule

// File: rtl/dram_disturb_gen.sv
module dram_disturb_gen #(
    parameter int ROW_W   = 16,
    parameter int BANK_W  = 3,
    parameter int MAX_AGG = 16,
    parameter int ITER_W  = 32,
    parameter int TRAS_W  = 8,
    parameter int TRP_W   = 8,
    parameter int OPEN_W  = 24,
    localparam int IDX_W     = (MAX_AGG > 1) ? $clog2(MAX_AGG) : 1,
    localparam int AGG_CNT_W = $clog2(MAX_AGG + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic                     abort_i,
    input  logic                     press_mode_i,
    input  logic [AGG_CNT_W-1:0]     agg_count_i,
    input  logic [MAX_AGG*ROW_W-1:0] agg_rows_i,
    input  logic [BANK_W-1:0]        bank_i,
    input  logic [ITER_W-1:0]        iter_i,
    input  logic [TRAS_W-1:0]        t_ras_i,
    input  logic [TRP_W-1:0]         t_rp_i,
    input  logic [OPEN_W-1:0]        open_time_i,
    output logic [1:0]               cmd_o,
    output logic [BANK_W-1:0]        cmd_bank_o,
    output logic [ROW_W-1:0]         cmd_row_o,
    output logic                     busy_o,
    output logic                     done_o
);
    import disturb_pkg::*;

    localparam logic [OPEN_W-1:0]    ONE_O = OPEN_W'(1);
    localparam logic [ITER_W-1:0]    ONE_I = ITER_W'(1);
    localparam logic [AGG_CNT_W-1:0] ONE_A = AGG_CNT_W'(1);
    localparam logic [AGG_CNT_W-1:0] MAX_A = AGG_CNT_W'(MAX_AGG);

    typedef struct packed {
        state_e                   st;
        logic [OPEN_W-1:0]        cnt;
        logic [ITER_W-1:0]        left;
        logic [IDX_W-1:0]         idx;
        logic                     press;
        logic [AGG_CNT_W-1:0]     nagg;
        logic [MAX_AGG*ROW_W-1:0] rows;
        logic [BANK_W-1:0]        bank;
        logic [OPEN_W-1:0]        open_len;
        logic [TRP_W-1:0]         rp_len;
        cmd_e                     cmd;
        logic [ROW_W-1:0]         row;
        logic                     done;
    } regs_t;

    regs_t q, d;

    logic [OPEN_W-1:0]    gl_open;
    logic [TRP_W-1:0]     gl_rp;
    logic [AGG_CNT_W-1:0] nagg_eff;
    logic [AGG_CNT_W-1:0] idx_inc;
    logic [IDX_W-1:0]     nxt_idx;
    logic [ROW_W-1:0]     nxt_row;

    disturb_gap_len #(
        .TRAS_W (TRAS_W),
        .TRP_W  (TRP_W),
        .OPEN_W (OPEN_W)
    ) i_gap_len (
        .press_i    (press_mode_i),
        .t_ras_i    (t_ras_i),
        .t_rp_i     (t_rp_i),
        .open_i     (open_time_i),
        .open_len_o (gl_open),
        .rp_len_o   (gl_rp)
    );

    disturb_row_pick #(
        .ROW_W   (ROW_W),
        .MAX_AGG (MAX_AGG),
        .IDX_W   (IDX_W)
    ) i_row_pick (
        .rows_i (q.rows),
        .idx_i  (nxt_idx),
        .row_o  (nxt_row)
    );

    always_comb begin
        if (agg_count_i == '0) begin
            nagg_eff = ONE_A;
        end else if (agg_count_i > MAX_A) begin
            nagg_eff = MAX_A;
        end else begin
            nagg_eff = agg_count_i;
        end
        idx_inc = AGG_CNT_W'(q.idx) + ONE_A;
        if (q.press || (idx_inc >= q.nagg)) begin
            nxt_idx = '0;
        end else begin
            nxt_idx = IDX_W'(idx_inc);
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.cmd  = CMD_NOP;
        unique case (q.st)
            ST_IDLE: begin
                if (!abort_i && start_i) begin
                    if (iter_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.press    = press_mode_i;
                        d.nagg     = nagg_eff;
                        d.rows     = agg_rows_i;
                        d.bank     = bank_i;
                        d.open_len = gl_open;
                        d.rp_len   = gl_rp;
                        d.left     = iter_i;
                        d.idx      = '0;
                        d.cmd      = CMD_ACT;
                        d.row      = agg_rows_i[ROW_W-1:0];
                        d.cnt      = gl_open - ONE_O;
                        d.st       = ST_OPEN;
                    end
                end
            end
            ST_OPEN: begin
                if (abort_i) begin
                    d.cmd = CMD_PRE;
                    d.st  = ST_IDLE;
                end else if (q.cnt == '0) begin
                    d.cmd  = CMD_PRE;
                    d.left = q.left - ONE_I;
                    d.cnt  = OPEN_W'(q.rp_len) - ONE_O;
                    d.st   = ST_RECOV;
                end else begin
                    d.cnt = q.cnt - ONE_O;
                end
            end
            ST_RECOV: begin
                if (abort_i) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == '0) begin
                    if (q.left == '0) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.idx = nxt_idx;
                        d.row = nxt_row;
                        d.cmd = CMD_ACT;
                        d.cnt = q.open_len - ONE_O;
                        d.st  = ST_OPEN;
                    end
                end else begin
                    d.cnt = q.cnt - ONE_O;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, cmd: CMD_NOP, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_o      = q.cmd;
    assign cmd_bank_o = q.bank;
    assign cmd_row_o  = q.row;
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;

    // Observation of the emitted command stream for the properties below.
    logic             open_seen_q;
    logic [ROW_W-1:0] act_row_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            open_seen_q <= 1'b0;
            act_row_q   <= '0;
        end else if (cmd_o == CMD_ACT) begin
            open_seen_q <= 1'b1;
            act_row_q   <= cmd_row_o;
        end else if (cmd_o == CMD_PRE) begin
            open_seen_q <= 1'b0;
        end
    end

    p_act_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_ACT) |-> !open_seen_q);

    p_pre_open_row_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_PRE) |-> (open_seen_q && (cmd_row_o == act_row_q)));

    p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !open_seen_q));

    p_abort_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_i && busy_o) |=> (!busy_o && !done_o));

    p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !abort_i) |=> $stable(cmd_bank_o));

    p_press_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_o == CMD_ACT) && q.press) |-> (cmd_row_o == q.rows[ROW_W-1:0]));

endmodule

// File: tb/test_dram_disturb_gen.sv
`timescale 1ns/1ps
module test_dram_disturb_gen;

    localparam int ROW_W = 16;
    localparam int BANK_W = 3;
    localparam int MAX_AGG = 16;
    localparam int ACW = $clog2(MAX_AGG + 1);
    localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, PRE = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, abort_i = 1'b0, press_i = 1'b0;
    logic [ACW-1:0] agg_count_i = '0;
    logic [MAX_AGG*ROW_W-1:0] agg_rows_i = '0;
    logic [BANK_W-1:0] bank_i = '0;
    logic [31:0] iter_i = '0;
    logic [7:0] t_ras_i = '0, t_rp_i = '0;
    logic [23:0] open_time_i = '0;
    logic [1:0] cmd_o;
    logic [BANK_W-1:0] cmd_bank_o;
    logic [ROW_W-1:0] cmd_row_o;
    logic busy_o, done_o;

    logic [ROW_W-1:0] rows_b [MAX_AGG];
    int n_chk = 0, n_err = 0, cyc = 0;

    always #10 clk = ~clk;

    dram_disturb_gen i_dram_disturb_gen (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .abort_i(abort_i),
        .press_mode_i(press_i), .agg_count_i(agg_count_i), .agg_rows_i(agg_rows_i),
        .bank_i(bank_i), .iter_i(iter_i), .t_ras_i(t_ras_i), .t_rp_i(t_rp_i),
        .open_time_i(open_time_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .cmd_row_o(cmd_row_o), .busy_o(busy_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic chk(logic [1:0] ec, logic [ROW_W-1:0] er, logic [BANK_W-1:0] eb,
                       bit eb_busy, bit e_done, string req);
        bit ok;
        n_chk++;
        ok = (cmd_o == ec) && (busy_o == eb_busy) && (done_o == e_done);
        if (ec != NOP) ok = ok && (cmd_row_o == er) && (cmd_bank_o == eb);
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual cmd=%0d row=%h bank=%0d busy=%0b done=%0b expected cmd=%0d row=%h bank=%0d busy=%0b done=%0b",
                     req, cmd_o, cmd_row_o, cmd_bank_o, busy_o, done_o, ec, er, eb, eb_busy, e_done);
        end
    endtask

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic load_rows();
        for (int i = 0; i < MAX_AGG; i++) agg_rows_i[i*ROW_W +: ROW_W] = rows_b[i];
    endtask

    task automatic rand_rows();
        for (int i = 0; i < MAX_AGG; i++) rows_b[i] = ROW_W'($urandom);
        load_rows();
    endtask

    // Runs one job and compares every slot to the trace the requirements imply.
    task automatic run_job(bit press, int nagg, int iters, int tras, int trp, int opent,
                           logic [BANK_W-1:0] bank, bit poke, string req);
        int n_eff, olen, rlen;
        logic [ROW_W-1:0] er;
        n_eff = (nagg == 0) ? 1 : ((nagg > MAX_AGG) ? MAX_AGG : nagg);
        olen = max2(press ? max2(tras, opent) : tras, 1);
        rlen = max2(trp, 1);
        press_i = press; agg_count_i = ACW'(nagg); bank_i = bank; iter_i = 32'(iters);
        t_ras_i = 8'(tras); t_rp_i = 8'(trp); open_time_i = 24'(opent);
        load_rows();
        start_i = 1'b1;
        step();
        for (int it = 0; it < iters; it++) begin
            er = press ? rows_b[0] : rows_b[it % n_eff];
            chk(ACT, er, bank, 1, 0, req);
            for (int k = 1; k < olen; k++) begin
                if (poke) begin
                    start_i = 1'b1; press_i = ~press_i; bank_i = ~bank;
                    agg_rows_i = {MAX_AGG{16'hDEAD}}; iter_i = 32'd1;
                end
                step();
                chk(NOP, '0, bank, 1, 0, poke ? "R7" : "R3");
            end
            step();
            chk(PRE, er, bank, 1, 0, poke ? "R7" : "R3");
            for (int k = 1; k < rlen; k++) begin
                step();
                chk(NOP, '0, bank, 1, 0, "R3");
            end
            step();
        end
        chk(NOP, '0, bank, 0, 1, "R6");
        step();
        chk(NOP, '0, bank, 0, 0, "R6");
        load_rows();
    endtask

    task automatic launch_hammer(logic [BANK_W-1:0] bank, int tras, int trp, logic [31:0] iters);
        press_i = 1'b0; agg_count_i = ACW'(2); bank_i = bank; iter_i = iters;
        t_ras_i = 8'(tras); t_rp_i = 8'(trp); open_time_i = '0;
        load_rows();
        start_i = 1'b1;
        step();
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rand_rows();
        repeat (3) step();
        chk(NOP, '0, '0, 0, 0, "R1");
        rst_n = 1'b1;
        step();
        chk(NOP, '0, '0, 0, 0, "R1");

        // two-sided ping-pong
        run_job(0, 2, 6, 2, 1, 0, 3'd5, 0, "R2");
        // nine-sided with minimum gaps
        run_job(0, 9, 18, 0, 0, 0, 3'd1, 0, "R2");
        // count 0 acts as one row, count above depth clamps
        run_job(0, 0, 3, 1, 2, 0, 3'd2, 0, "R2");
        run_job(0, 20, 17, 0, 1, 0, 3'd6, 0, "R2");
        // press: open time dominates, then gap dominates
        run_job(1, 4, 2, 5, 3, 40, 3'd7, 0, "R4");
        run_job(1, 4, 2, 6, 1, 2, 3'd0, 0, "R4");
        // start and input changes while busy
        run_job(0, 4, 5, 4, 2, 0, 3'd3, 1, "R7");

        // zero iterations
        press_i = 1'b0; iter_i = '0; start_i = 1'b1;
        step();
        chk(NOP, '0, '0, 0, 1, "R5");
        step();
        chk(NOP, '0, '0, 0, 0, "R5");

        // abort with the row open
        launch_hammer(3'd4, 3, 3, 32'd10);
        chk(ACT, rows_b[0], 3'd4, 1, 0, "R8");
        abort_i = 1'b1; step(); abort_i = 1'b0;
        chk(PRE, rows_b[0], 3'd4, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");

        // abort in the same cycle as the scheduled precharge
        launch_hammer(3'd2, 3, 3, 32'd10);
        chk(ACT, rows_b[0], 3'd2, 1, 0, "R8");
        step(); chk(NOP, '0, '0, 1, 0, "R3");
        step(); chk(NOP, '0, '0, 1, 0, "R3");
        abort_i = 1'b1; step(); abort_i = 1'b0;
        chk(PRE, rows_b[0], 3'd2, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");

        // abort during recovery: no command
        launch_hammer(3'd1, 1, 3, 32'd10);
        chk(ACT, rows_b[0], 3'd1, 1, 0, "R8");
        step(); chk(PRE, rows_b[0], 3'd1, 1, 0, "R3");
        abort_i = 1'b1; step(); abort_i = 1'b0;
        chk(NOP, '0, '0, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");

        // abort beats start while idle
        iter_i = 32'd4; abort_i = 1'b1; start_i = 1'b1;
        step(); abort_i = 1'b0;
        chk(NOP, '0, '0, 0, 0, "R8");
        step(); chk(NOP, '0, '0, 0, 0, "R8");

        // full 32-bit count runs without early completion
        launch_hammer(3'd6, 1, 1, 32'hFFFF_FFFF);
        for (int it = 0; it < 6; it++) begin
            chk(ACT, rows_b[it % 2], 3'd6, 1, 0, "R5");
            step();
            chk(PRE, rows_b[it % 2], 3'd6, 1, 0, "R5");
            step();
        end
        abort_i = 1'b1; step(); abort_i = 1'b0;
        chk(PRE, rows_b[0], 3'd6, 0, 0, "R8");
        step();

        // constrained random jobs
        for (int j = 0; j < 12; j++) begin
            rand_rows();
            run_job(1'($urandom_range(0, 1)), int'($urandom_range(0, MAX_AGG + 2)),
                    int'($urandom_range(1, 12)), int'($urandom_range(0, 6)),
                    int'($urandom_range(0, 5)), int'($urandom_range(0, 20)),
                    BANK_W'($urandom), 1'($urandom_range(0, 1)), "R5");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule